// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block is the control state machine that brings a display PLL and its PHY clock path up and down in a fixed order. A level request (`pwr_req`) starts the power-up walk. The walk turns on the master PHY bias and then its system clock mux. When a slave PHY is attached for dual-link operation, the same two steps follow for the slave. Each bias step is followed by a settle wait. The walk then pulses a configuration-load strobe and starts the PLL. After that it polls the PLL lock input at a fixed interval until lock is seen or a timeout expires.

On lock, the `pll_on` flag is raised. The global clock enables are then set, master first, and after them the readback buffer enables, master first. On timeout, the block parks with `lock_err` set and does not open the clock gates.

Dropping the request starts power-down. On the master, the global clock is gated first, then the PLL is stopped, then the readback buffer is cleared, then the mux, then the bias, followed by a settle wait. The slave follows with the same order minus the PLL stop. `pll_on` clears only when the whole walk has finished. All delays are counted in system clock cycles, derived from a cycles-per-microsecond parameter.

States: OFF, UP_M_CTRL, UP_M_MUX, UP_M_SETTLE, UP_S_CTRL, UP_S_MUX, UP_S_SETTLE, CFG, START, POLL_CHK, POLL_WAIT, UP_M_GCLK, UP_S_GCLK, UP_M_RBUF, UP_S_RBUF, ON, FAIL, DN_M_GATE, DN_STOP, DN_M_RBUF, DN_M_MUX, DN_M_CTRL, DN_M_SETTLE, DN_S_GATE, DN_S_RBUF, DN_S_MUX, DN_S_CTRL, DN_S_SETTLE.

Transitions:
- OFF to UP_M_CTRL while the request is high.
- Through the up chain one state per cycle. The SETTLE states stay put until the timer expires. The slave states are skipped when no slave was latched.
- POLL_CHK goes to UP_M_GCLK on lock, to FAIL after the last check, and to POLL_WAIT otherwise. POLL_WAIT returns to POLL_CHK when its timer expires.
- ON or FAIL goes to DN_M_GATE once the request is low.
- Down the chain to OFF.

Top module: `pll_pwr_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, every output is 0.
- R2: Power-up sets `m_phy_bias` before `m_sys_mux`. When a slave is latched, `s_phy_bias` then `s_sys_mux` follow, and each mux rise is followed by at least SETTLE_CYC cycles before the next action. A mux enable is never high while its bias bit is low.
- R3: After the bias steps, `cfg_load` pulses high for exactly one cycle, once per power-up. `pll_run` rises after that pulse, and `pll_run` is only high while the master bias and mux are both on.
- R4: The lock input is sampled in the cycle right after `pll_run` rises and then every POLL_CYC cycles. It is ignored between samples. A high sample raises `pll_on` one cycle later.
- R5: If all NUM_POLLS+1 samples (checks 0 to NUM_POLLS) are low, `lock_err` rises one cycle after the last sample. `pll_on`, the gclk and the rbuf enables stay 0, and a lock arriving later is ignored.
- R6: After lock the enables rise in the order `m_gclk_en`, `s_gclk_en` (if slave), `m_rbuf_en`, `s_rbuf_en` (if slave). No gclk or rbuf enable is high while `pll_on` is low.
- R7: Power-down clears `m_gclk_en`, then `pll_run`, `m_rbuf_en`, `m_sys_mux` and `m_phy_bias` in that order, then waits at least SETTLE_CYC cycles. With a slave it then clears `s_gclk_en`, `s_rbuf_en`, `s_sys_mux` and `s_phy_bias` and waits again. `pll_on` clears last.
- R8: `slave_present` is sampled only when a power-up starts. A change during the sequence has no effect, and slave outputs never rise when no slave was latched.
- R9: A request drop during power-up is held until power-up completes. A request rise during power-down is held until power-down completes, after which power-up restarts.
- R10: `lock_err` stays set through power-down and clears when the next power-up starts, before `m_phy_bias` rises.
- R11: SETTLE_CYC = ceil(CYC_PER_US*SETTLE_NS/1000) (at least 1), POLL_CYC = CYC_PER_US*POLL_US (at least 2), and NUM_POLLS = TIMEOUT_US/POLL_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Level request: 1 = PLL wanted up |
| slave_present | input | 1 | A slave PHY is attached (sampled at power-up start) |
| pll_lock | input | 1 | PLL lock status bit |
| m_phy_bias | output | 1 | Master PHY bias control bit |
| m_sys_mux | output | 1 | Master system mux enabled |
| m_gclk_en | output | 1 | Master global clock enable |
| m_rbuf_en | output | 1 | Master readback buffer enable |
| s_phy_bias | output | 1 | Slave PHY bias control bit |
| s_sys_mux | output | 1 | Slave system mux enabled |
| s_gclk_en | output | 1 | Slave global clock enable |
| s_rbuf_en | output | 1 | Slave readback buffer enable |
| cfg_load | output | 1 | One-cycle strobe to load the rate configuration |
| pll_run | output | 1 | PLL start control |
| pll_on | output | 1 | PLL locked and in service |
| lock_err | output | 1 | Lock timed out on the last power-up |

## Verification
A table of power-up cases varies the slave attachment and the check at which lock first appears. The cases cover lock present before the start, lock at an early check, lock at the very last check, and no lock at all. Together they separate an off-by-one in the poll interval or the check count from a correct timeout. Each case is followed by a power-down whose edge ordering is compared in both single- and dual-link form. Directed runs then toggle `slave_present` mid-sequence, reverse the request during each walk, and raise lock after a timeout, which shows whether the latched and held state really ignores these inputs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [4:0] {
        S_OFF,
        S_UP_M_CTRL,
        S_UP_M_MUX,
        S_UP_M_SETTLE,
        S_UP_S_CTRL,
        S_UP_S_MUX,
        S_UP_S_SETTLE,
        S_CFG,
        S_START,
        S_POLL_CHK,
        S_POLL_WAIT,
        S_UP_M_GCLK,
        S_UP_S_GCLK,
        S_UP_M_RBUF,
        S_UP_S_RBUF,
        S_ON,
        S_FAIL,
        S_DN_M_GATE,
        S_DN_STOP,
        S_DN_M_RBUF,
        S_DN_M_MUX,
        S_DN_M_CTRL,
        S_DN_M_SETTLE,
        S_DN_S_GATE,
        S_DN_S_RBUF,
        S_DN_S_MUX,
        S_DN_S_CTRL,
        S_DN_S_SETTLE
    } seq_state_e;

    // field positions inside one lane's control vector
    localparam int LN_CTRL   = 0;
    localparam int LN_MUX    = 1;
    localparam int LN_GCLK   = 2;
    localparam int LN_RBUF   = 3;
    localparam int LN_FIELDS = 4;

    localparam int LANE_M    = 0;
    localparam int LANE_S    = 1;
    localparam int NUM_LANES = 2;

endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    // a loaded value of N keeps the waiting state for N cycles
    assign done = (cnt == W'(1));

    // R4, R11: a new wait is only started once the previous one has run out
    assert_timer_idle_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt == '0));

endmodule

// File: rtl/pps_poll_budget.sv
module pps_poll_budget #(
    parameter int MAXN = 50,
    parameter int W    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

    assign last = (cnt == W'(MAXN));

    // R5: the number of checks never runs past the budget
    assert_poll_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(MAXN));

endmodule

// File: rtl/pps_lane.sv
module pps_lane
    import pll_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LN_FIELDS-1:0] set_i,
    input  logic [LN_FIELDS-1:0] clr_i,
    output logic [LN_FIELDS-1:0] lvl_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= '0;
        end else begin
            lvl_o <= (lvl_o | set_i) & ~clr_i;
        end
    end

    // R2, R7: the mux is only on while the bias bit is on
    assert_mux_needs_bias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o[LN_MUX] |-> lvl_o[LN_CTRL]);

    // R7: the sequencer never asks to set and clear one field together
    assert_no_set_clr_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i & clr_i) == '0);

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int SETTLE_NS  = 250,
    parameter int POLL_US    = 100,
    parameter int TIMEOUT_US = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic slave_present,
    input  logic pll_lock,
    output logic m_phy_bias,
    output logic m_sys_mux,
    output logic m_gclk_en,
    output logic m_rbuf_en,
    output logic s_phy_bias,
    output logic s_sys_mux,
    output logic s_gclk_en,
    output logic s_rbuf_en,
    output logic cfg_load,
    output logic pll_run,
    output logic pll_on,
    output logic lock_err
);
    localparam int SETTLE_RAW = (CYC_PER_US * SETTLE_NS + 999) / 1000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int POLL_RAW   = CYC_PER_US * POLL_US;
    localparam int POLL_CYC   = (POLL_RAW < 2) ? 2 : POLL_RAW;
    localparam int NPOLL_RAW  = TIMEOUT_US / POLL_US;
    localparam int NUM_POLLS  = (NPOLL_RAW < 1) ? 1 : NPOLL_RAW;
    localparam int TMR_MAX    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
    localparam int TW         = $clog2(TMR_MAX + 1);
    localparam int PW         = $clog2(NUM_POLLS + 1);

    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC);
    localparam logic [TW-1:0] POLL_V   = TW'(POLL_CYC - 1);

    seq_state_e st, nxt;
    logic       slv_q;

    logic [NUM_LANES-1:0][LN_FIELDS-1:0] ln_set, ln_clr, ln_lvl;
    logic          cfg_pulse, run_set, run_clr, on_set, on_clr, err_set, err_clr;
    logic          tmr_load, tmr_done, poll_clr, poll_inc, poll_last, cap_slv;
    logic [TW-1:0] tmr_val;

    pps_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .done  (tmr_done)
    );

    pps_poll_budget #(.MAXN(NUM_POLLS), .W(PW)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pps_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ln_set[g]),
            .clr_i (ln_clr[g]),
            .lvl_o (ln_lvl[g])
        );
    end

    // state register and slave latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_OFF;
            slv_q <= 1'b0;
        end else begin
            st <= nxt;
            if (cap_slv) slv_q <= slave_present;
        end
    end

    // next state and action decode
    always_comb begin
        nxt       = st;
        ln_set    = '0;
        ln_clr    = '0;
        cfg_pulse = 1'b0;
        run_set   = 1'b0;
        run_clr   = 1'b0;
        on_set    = 1'b0;
        on_clr    = 1'b0;
        err_set   = 1'b0;
        err_clr   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = SETTLE_V;
        poll_clr  = 1'b0;
        poll_inc  = 1'b0;
        cap_slv   = 1'b0;
        unique case (st)
            S_OFF: begin
                if (pwr_req) begin
                    err_clr = 1'b1;
                    cap_slv = 1'b1;
                    nxt     = S_UP_M_CTRL;
                end
            end
            S_UP_M_CTRL: begin
                ln_set[LANE_M][LN_CTRL] = 1'b1;
                nxt = S_UP_M_MUX;
            end
            S_UP_M_MUX: begin
                ln_set[LANE_M][LN_MUX] = 1'b1;
                tmr_load = 1'b1;
                nxt = S_UP_M_SETTLE;
            end
            S_UP_M_SETTLE: begin
                if (tmr_done) nxt = slv_q ? S_UP_S_CTRL : S_CFG;
            end
            S_UP_S_CTRL: begin
                ln_set[LANE_S][LN_CTRL] = 1'b1;
                nxt = S_UP_S_MUX;
            end
            S_UP_S_MUX: begin
                ln_set[LANE_S][LN_MUX] = 1'b1;
                tmr_load = 1'b1;
                nxt = S_UP_S_SETTLE;
            end
            S_UP_S_SETTLE: begin
                if (tmr_done) nxt = S_CFG;
            end
            S_CFG: begin
                cfg_pulse = 1'b1;
                nxt = S_START;
            end
            S_START: begin
                run_set  = 1'b1;
                poll_clr = 1'b1;
                nxt = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                if (pll_lock) begin
                    on_set = 1'b1;
                    nxt = S_UP_M_GCLK;
                end else if (poll_last) begin
                    err_set = 1'b1;
                    nxt = S_FAIL;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = POLL_V;
                    poll_inc = 1'b1;
                    nxt = S_POLL_WAIT;
                end
            end
            S_POLL_WAIT: begin
                if (tmr_done) nxt = S_POLL_CHK;
            end
            S_UP_M_GCLK: begin
                ln_set[LANE_M][LN_GCLK] = 1'b1;
                nxt = slv_q ? S_UP_S_GCLK : S_UP_M_RBUF;
            end
            S_UP_S_GCLK: begin
                ln_set[LANE_S][LN_GCLK] = 1'b1;
                nxt = S_UP_M_RBUF;
            end
            S_UP_M_RBUF: begin
                ln_set[LANE_M][LN_RBUF] = 1'b1;
                nxt = slv_q ? S_UP_S_RBUF : S_ON;
            end
            S_UP_S_RBUF: begin
                ln_set[LANE_S][LN_RBUF] = 1'b1;
                nxt = S_ON;
            end
            S_ON, S_FAIL: begin
                if (!pwr_req) nxt = S_DN_M_GATE;
            end
            S_DN_M_GATE: begin
                ln_clr[LANE_M][LN_GCLK] = 1'b1;
                nxt = S_DN_STOP;
            end
            S_DN_STOP: begin
                run_clr = 1'b1;
                nxt = S_DN_M_RBUF;
            end
            S_DN_M_RBUF: begin
                ln_clr[LANE_M][LN_RBUF] = 1'b1;
                nxt = S_DN_M_MUX;
            end
            S_DN_M_MUX: begin
                ln_clr[LANE_M][LN_MUX] = 1'b1;
                nxt = S_DN_M_CTRL;
            end
            S_DN_M_CTRL: begin
                ln_clr[LANE_M][LN_CTRL] = 1'b1;
                tmr_load = 1'b1;
                nxt = S_DN_M_SETTLE;
            end
            S_DN_M_SETTLE: begin
                if (tmr_done) begin
                    if (slv_q) begin
                        nxt = S_DN_S_GATE;
                    end else begin
                        on_clr = 1'b1;
                        nxt = S_OFF;
                    end
                end
            end
            S_DN_S_GATE: begin
                ln_clr[LANE_S][LN_GCLK] = 1'b1;
                nxt = S_DN_S_RBUF;
            end
            S_DN_S_RBUF: begin
                ln_clr[LANE_S][LN_RBUF] = 1'b1;
                nxt = S_DN_S_MUX;
            end
            S_DN_S_MUX: begin
                ln_clr[LANE_S][LN_MUX] = 1'b1;
                nxt = S_DN_S_CTRL;
            end
            S_DN_S_CTRL: begin
                ln_clr[LANE_S][LN_CTRL] = 1'b1;
                tmr_load = 1'b1;
                nxt = S_DN_S_SETTLE;
            end
            S_DN_S_SETTLE: begin
                if (tmr_done) begin
                    on_clr = 1'b1;
                    nxt = S_OFF;
                end
            end
            default: nxt = S_OFF;
        endcase
    end

    // registered status and strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_load <= 1'b0;
            pll_run  <= 1'b0;
            pll_on   <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            cfg_load <= cfg_pulse;
            pll_run  <= (pll_run  | run_set) & ~run_clr;
            pll_on   <= (pll_on   | on_set)  & ~on_clr;
            lock_err <= (lock_err | err_set) & ~err_clr;
        end
    end

    assign m_phy_bias = ln_lvl[LANE_M][LN_CTRL];
    assign m_sys_mux  = ln_lvl[LANE_M][LN_MUX];
    assign m_gclk_en  = ln_lvl[LANE_M][LN_GCLK];
    assign m_rbuf_en  = ln_lvl[LANE_M][LN_RBUF];
    assign s_phy_bias = ln_lvl[LANE_S][LN_CTRL];
    assign s_sys_mux  = ln_lvl[LANE_S][LN_MUX];
    assign s_gclk_en  = ln_lvl[LANE_S][LN_GCLK];
    assign s_rbuf_en  = ln_lvl[LANE_S][LN_RBUF];

    // R3: config strobe is a single cycle wide
    assert_cfg_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !cfg_load);

    // R3: the PLL only runs with master bias and mux on
    assert_run_needs_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pll_run |-> (m_phy_bias && m_sys_mux));

    // R4: pll_on only rises after a high lock sample
    assert_on_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_on) |-> $past(pll_lock));

    // R5: an error and an in-service PLL never coexist
    assert_err_blocks_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> (!pll_on && !m_gclk_en && !s_gclk_en));

    // R6: clock and buffer enables only while the PLL is on
    assert_gates_need_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_gclk_en || s_gclk_en || m_rbuf_en || s_rbuf_en) |-> pll_on);

    // R7: the master clock is already gated when the PLL stops
    assert_gate_before_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_run) |-> !m_gclk_en);

    // R8: slave lane stays off unless a slave was latched
    assert_slave_only_if_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_q |-> !s_phy_bias);

endmodule

// File: tb/tb_pll_pwr_seq.sv
module tb_pll_pwr_seq;

    localparam int CPU        = 8;
    localparam int SET_NS     = 250;
    localparam int P_US       = 100;
    localparam int TO_US      = 2000;
    localparam int SETTLE_CYC = (CPU * SET_NS + 999) / 1000;
    localparam int POLL_CYC   = CPU * P_US;
    localparam int NUM_POLLS  = TO_US / P_US;
    localparam int WD_LIMIT   = 190000;

    // signal indices for the edge monitor
    localparam int I_MB = 0, I_MM = 1, I_MG = 2, I_MR = 3;
    localparam int I_SB = 4, I_SM = 5, I_SG = 6, I_SR = 7;
    localparam int I_CFG = 8, I_RUN = 9, I_ON = 10, I_ERR = 11;
    localparam int NSIG = 12;

    // stimulus table: {slave attached, check index of first lock (-1 = never)}
    localparam int VEC_N = 7;
    localparam int VTAB [VEC_N][2] = '{
        '{0, 0}, '{1, 0}, '{0, 3}, '{1, 2}, '{1, NUM_POLLS}, '{0, -1}, '{1, -1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_req = 1'b0;
    logic slave_present = 1'b0;
    logic pll_lock = 1'b0;
    logic m_phy_bias, m_sys_mux, m_gclk_en, m_rbuf_en;
    logic s_phy_bias, s_sys_mux, s_gclk_en, s_rbuf_en;
    logic cfg_load, pll_run, pll_on, lock_err;

    pll_pwr_seq #(
        .CYC_PER_US (CPU),
        .SETTLE_NS  (SET_NS),
        .POLL_US    (P_US),
        .TIMEOUT_US (TO_US)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_req       (pwr_req),
        .slave_present (slave_present),
        .pll_lock      (pll_lock),
        .m_phy_bias    (m_phy_bias),
        .m_sys_mux     (m_sys_mux),
        .m_gclk_en     (m_gclk_en),
        .m_rbuf_en     (m_rbuf_en),
        .s_phy_bias    (s_phy_bias),
        .s_sys_mux     (s_sys_mux),
        .s_gclk_en     (s_gclk_en),
        .s_rbuf_en     (s_rbuf_en),
        .cfg_load      (cfg_load),
        .pll_run       (pll_run),
        .pll_on        (pll_on),
        .lock_err      (lock_err)
    );

    always #2ns clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rise_t [NSIG];
    int fall_t [NSIG];
    int cfg_cnt = 0;
    bit s_seen = 1'b0;
    logic [NSIG-1:0] prev = '0;
    logic [NSIG-1:0] sig;

    assign sig = {lock_err, pll_on, pll_run, cfg_load,
                  s_rbuf_en, s_gclk_en, s_sys_mux, s_phy_bias,
                  m_rbuf_en, m_gclk_en, m_sys_mux, m_phy_bias};

    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < NSIG; i++) begin
            if (sig[i] && !prev[i] && rise_t[i] < 0) rise_t[i] = cyc;
            if (!sig[i] && prev[i] && fall_t[i] < 0) fall_t[i] = cyc;
        end
        if (cfg_load && !prev[I_CFG]) cfg_cnt = cfg_cnt + 1;
        if (s_phy_bias || s_sys_mux || s_gclk_en || s_rbuf_en) s_seen = 1'b1;
        prev = sig;
        if (cyc > WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1ns;
    endtask

    task automatic clear_marks();
        for (int i = 0; i < NSIG; i++) begin
            rise_t[i] = -1;
            fall_t[i] = -1;
        end
        cfg_cnt = 0;
        s_seen = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    bit prev_fail = 1'b0;

    task automatic do_up(input int slv, input int lk);
        int s0;
        clear_marks();
        pll_lock = (lk == 0);
        slave_present = slv[0];
        pwr_req = 1'b1;
        while (!pll_run) tick();
        tick();
        s0 = rise_t[I_RUN];
        if (prev_fail) begin
            chk(fall_t[I_ERR] >= 0 && fall_t[I_ERR] < rise_t[I_MB], "R10",
                "lock_err cleared before bias rise", fall_t[I_ERR], rise_t[I_MB] - 1);
        end
        chk(rise_t[I_MB] >= 0 && rise_t[I_MB] < rise_t[I_MM], "R2",
            "master bias before mux", rise_t[I_MB], rise_t[I_MM] - 1);
        if (slv != 0) begin
            chk(rise_t[I_SB] - rise_t[I_MM] >= SETTLE_CYC, "R11",
                "master settle gap", rise_t[I_SB] - rise_t[I_MM], SETTLE_CYC);
            chk(rise_t[I_SB] < rise_t[I_SM], "R2", "slave bias before mux",
                rise_t[I_SB], rise_t[I_SM] - 1);
            chk(rise_t[I_CFG] - rise_t[I_SM] >= SETTLE_CYC, "R2",
                "slave settle before cfg", rise_t[I_CFG] - rise_t[I_SM], SETTLE_CYC);
        end else begin
            chk(rise_t[I_CFG] - rise_t[I_MM] >= SETTLE_CYC, "R11",
                "master settle before cfg", rise_t[I_CFG] - rise_t[I_MM], SETTLE_CYC);
        end
        chk(rise_t[I_CFG] >= 0 && rise_t[I_CFG] < s0, "R3", "cfg before run",
            rise_t[I_CFG], s0 - 1);
        if (lk > 0) begin
            while (cyc < s0 + (lk - 1) * POLL_CYC + POLL_CYC / 2) tick();
            pll_lock = 1'b1;
        end
        if (lk >= 0) begin
            while (!pll_on) tick();
            repeat (12) tick();
            chk(rise_t[I_ON] == s0 + 1 + lk * POLL_CYC, "R4", "pll_on rise cycle",
                rise_t[I_ON], s0 + 1 + lk * POLL_CYC);
            chk(cfg_cnt == 1, "R3", "cfg pulse count", cfg_cnt, 1);
            chk(rise_t[I_MG] > rise_t[I_ON], "R6", "master gclk after on",
                rise_t[I_MG], rise_t[I_ON] + 1);
            if (slv != 0) begin
                chk(rise_t[I_SG] > rise_t[I_MG], "R6", "slave gclk after master",
                    rise_t[I_SG], rise_t[I_MG] + 1);
                chk(rise_t[I_MR] > rise_t[I_SG], "R6", "master rbuf after gclks",
                    rise_t[I_MR], rise_t[I_SG] + 1);
                chk(rise_t[I_SR] > rise_t[I_MR], "R6", "slave rbuf after master",
                    rise_t[I_SR], rise_t[I_MR] + 1);
            end else begin
                chk(rise_t[I_MR] > rise_t[I_MG], "R6", "master rbuf after gclk",
                    rise_t[I_MR], rise_t[I_MG] + 1);
                chk(!s_seen, "R8", "no slave activity", s_seen, 0);
            end
            chk(!lock_err, "R5", "no error on lock", lock_err, 0);
            prev_fail = 1'b0;
        end else begin
            while (!lock_err) tick();
            tick();
            chk(rise_t[I_ERR] == s0 + 1 + NUM_POLLS * POLL_CYC, "R5", "timeout cycle",
                rise_t[I_ERR], s0 + 1 + NUM_POLLS * POLL_CYC);
            chk(rise_t[I_MG] < 0 && rise_t[I_MR] < 0 && !pll_on, "R5",
                "no gates after timeout", rise_t[I_MG], -1);
            pll_lock = 1'b1;
            repeat (2 * POLL_CYC) tick();
            chk(!pll_on && !m_gclk_en, "R5", "late lock ignored", pll_on, 0);
            prev_fail = 1'b1;
        end
    endtask

    task automatic do_down(input int slv, input bit ok);
        clear_marks();
        pwr_req = 1'b0;
        while (m_phy_bias || s_phy_bias) tick();
        repeat (SETTLE_CYC + 6) tick();
        chk(sig[I_RUN:0] == '0 && !pll_on, "R7", "all off after down",
            int'(sig[I_ON:0]), 0);
        if (ok) begin
            chk(fall_t[I_MG] < fall_t[I_RUN] && fall_t[I_MG] >= 0, "R7",
                "gate before stop", fall_t[I_MG], fall_t[I_RUN] - 1);
            chk(fall_t[I_MR] > fall_t[I_RUN], "R7", "rbuf after stop",
                fall_t[I_MR], fall_t[I_RUN] + 1);
        end
        chk(fall_t[I_MM] > fall_t[I_RUN] && fall_t[I_MB] > fall_t[I_MM], "R7",
            "mux then bias off", fall_t[I_MB], fall_t[I_MM] + 1);
        if (slv != 0) begin
            chk(fall_t[I_SB] - fall_t[I_MB] >= SETTLE_CYC, "R7",
                "master settle before slave", fall_t[I_SB] - fall_t[I_MB], SETTLE_CYC);
            chk(fall_t[I_SM] < fall_t[I_SB], "R7", "slave mux then bias",
                fall_t[I_SM], fall_t[I_SB] - 1);
            if (ok) begin
                chk(fall_t[I_SG] > fall_t[I_MB] && fall_t[I_SR] > fall_t[I_SG], "R7",
                    "slave gate then rbuf", fall_t[I_SR], fall_t[I_SG] + 1);
                chk(fall_t[I_ON] - fall_t[I_SB] >= SETTLE_CYC, "R7",
                    "pll_on clears last", fall_t[I_ON] - fall_t[I_SB], SETTLE_CYC);
            end
        end else if (ok) begin
            chk(fall_t[I_ON] - fall_t[I_MB] >= SETTLE_CYC, "R7",
                "pll_on clears last", fall_t[I_ON] - fall_t[I_MB], SETTLE_CYC);
        end
        pll_lock = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NSIG; i++) begin
            rise_t[i] = -1;
            fall_t[i] = -1;
        end
        repeat (5) tick();
        chk(sig == '0, "R1", "outputs in reset", int'(sig), 0);
        rst_n = 1'b1;
        repeat (4) tick();
        chk(sig == '0, "R1", "outputs idle after reset", int'(sig), 0);

        for (int v = 0; v < VEC_N; v++) begin
            do_up(VTAB[v][0], VTAB[v][1]);
            do_down(VTAB[v][0], VTAB[v][1] >= 0);
        end

        // R8: slave_present drops mid power-up, slave still runs
        clear_marks();
        pll_lock = 1'b1;
        slave_present = 1'b1;
        pwr_req = 1'b1;
        while (!m_phy_bias) tick();
        slave_present = 1'b0;
        while (!pll_on) tick();
        repeat (10) tick();
        chk(s_rbuf_en == 1'b1, "R8", "latched slave kept", s_rbuf_en, 1);
        do_down(1, 1'b1);

        // R8: slave_present rises mid power-up, no slave activity
        clear_marks();
        pll_lock = 1'b1;
        slave_present = 1'b0;
        pwr_req = 1'b1;
        while (!m_phy_bias) tick();
        slave_present = 1'b1;
        while (!pll_on) tick();
        repeat (10) tick();
        chk(!s_seen, "R8", "late slave ignored", s_seen, 0);
        do_down(0, 1'b1);

        // R9: request drops during power-up
        clear_marks();
        pll_lock = 1'b1;
        slave_present = 1'b0;
        pwr_req = 1'b1;
        while (!m_phy_bias) tick();
        pwr_req = 1'b0;
        while (fall_t[I_ON] < 0) tick();
        repeat (4) tick();
        chk(rise_t[I_MR] >= 0 && fall_t[I_ON] > rise_t[I_ON], "R9",
            "up completed before down", rise_t[I_MR], 1);
        chk(sig == '0, "R9", "idle after held drop", int'(sig), 0);

        // R9: request rises again during power-down
        pll_lock = 1'b1;
        pwr_req = 1'b1;
        while (!pll_on) tick();
        repeat (10) tick();
        clear_marks();
        pwr_req = 1'b0;
        while (m_gclk_en) tick();
        pwr_req = 1'b1;
        while (rise_t[I_ON] < 0) tick();
        repeat (10) tick();
        chk(fall_t[I_MB] >= 0 && rise_t[I_MB] > fall_t[I_MB], "R9",
            "down finished before restart", rise_t[I_MB], fall_t[I_MB] + 1);
        chk(fall_t[I_ON] >= 0 && fall_t[I_ON] < rise_t[I_MB], "R9",
            "pll_on cleared before restart", fall_t[I_ON], rise_t[I_MB] - 1);
        do_down(0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule